// File: doc/BRIEF.md
# Paged Address Translation Cache with Access Checks

This block caches page-table entries for a 32-bit paged address space and turns a virtual lookup address into a physical one in a single registered step. Each cached entry covers either a 4 KB page or a 4 MB page, chosen by the page-size bit of the entry itself. The same lookup also checks the access against the entry's present, writable and user bits. It reports a page fault with vector number 5 when a check fails.

A page-table walker outside the block refills entries through a write port. It also clears single entries by address through an invalidate port. When the paging-enable flag is low, the block passes addresses through unchanged. A write that hits a clean entry is reported as a miss. The walker can then mark the page dirty in memory and refill the entry, which the block rewrites in place.

Entry word bit positions used throughout: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 3 accessed, bit 4 dirty, bit 5 write-through, bit 6 cache-disable, bit 7 page size (1 = 4 MB). The upper bits hold the physical page base.

Top module: `tlbx_xlate`

## Requirements
- R1: Synchronous reset clears every entry's valid flag, sets the replacement pointer to entry 0, and holds all outputs at zero. The first paged lookup after reset misses.
- R2: With `paging_on` low, a lookup returns `out_paddr` equal to the lookup address with `out_hit` set. No fault is raised and both attribute outputs are 0, whatever the entries hold.
- R3: A lookup that hits a 4 KB entry (bit 7 = 0) returns entry bits 31:12 joined with address bits 11:0. `out_wthru` carries entry bit 5 and `out_nocache` carries entry bit 6.
- R4: An entry with bit 7 = 1 matches on address bits 31:22 only. A hit on it returns entry bits 31:22 joined with address bits 21:0.
- R5: A paged lookup that matches no valid entry gives `out_miss` = 1, `out_hit` = 0 and `out_paddr` = 0. At most one of hit, miss and fault is ever set.
- R6: A matching entry raises `out_fault` with `out_fault_vec` = 5, and neither hit nor miss, in any of three cases: entry bit 0 is 0, a write finds bit 1 at 0, or a user-mode lookup finds bit 2 at 0. `out_fault_vec` is 0 whenever no fault is reported.
- R7: A write lookup that passes the checks but finds entry bit 4 (dirty) at 0 is reported as a miss, not a hit.
- R8: A refill whose page already matches a valid entry overwrites that entry. Any other refill writes the entry at the round-robin pointer and then advances the pointer, so the ninth distinct refill after reset replaces the first.
- R9: An invalidate clears every valid entry that matches its address, each entry under its own page size. An invalidate in the same cycle as a refill wins: the refill is dropped and the pointer stays where it is.
- R10: Outputs are registered one cycle after the lookup inputs. `out_valid` follows `lk_valid`, and every other output is 0 when `out_valid` is 0. A refill or invalidate in the lookup cycle is not yet visible to that lookup.
- R11: When several entries match a lookup, the lowest-numbered one decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_on | input | 1 | Translation enable flag |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup is from user mode |
| fill_en | input | 1 | Refill strobe |
| fill_vaddr | input | 32 | Virtual address of the page being refilled |
| fill_pte | input | 32 | Entry word written by the refill |
| inv_en | input | 1 | Invalidate strobe |
| inv_vaddr | input | 32 | Address whose cached entries are removed |
| out_valid | output | 1 | Result valid, one cycle after `lk_valid` |
| out_paddr | output | 32 | Physical address |
| out_hit | output | 1 | Translation succeeded |
| out_miss | output | 1 | No usable entry; walker must refill |
| out_fault | output | 1 | Access check failed |
| out_fault_vec | output | 8 | Fault vector number (5) when `out_fault` is set |
| out_wthru | output | 1 | Write-through attribute of the hit page |
| out_nocache | output | 1 | Cache-disable attribute of the hit page |

## Verification
Directed lookups walk one entry of each kind through its outcome: a clean 4 KB hit, a 4 MB hit at the far end of its range, each of the three fault causes, and a write to a clean page. The same page is then refilled dirty, which shows whether refill rewrites in place or takes a fresh slot. Nine distinct refills separate true round-robin replacement from overwrite-in-place. A 4 KB page set inside a 4 MB page shows both the lowest-index priority and the rule that an invalidate clears all matching entries. A random phase draws addresses from a small pool of overlapping 4 KB and 4 MB pages, with random entry bits and a mix of refill, invalidate and paging-off cycles. This exercises same-cycle refill and invalidate against a model that the bench keeps from the requirements.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  // Bit positions inside a cached page-table entry word.
  localparam int PTE_PRESENT  = 0;
  localparam int PTE_WRITE    = 1;
  localparam int PTE_USER     = 2;
  localparam int PTE_ACCESSED = 3;
  localparam int PTE_DIRTY    = 4;
  localparam int PTE_WTHRU    = 5;
  localparam int PTE_NOCACHE  = 6;
  localparam int PTE_LARGE    = 7;

  // Outcome class of one lookup.
  typedef enum logic [1:0] {
    RES_MISS   = 2'd0,
    RES_HIT    = 2'd1,
    RES_FAULT  = 2'd2,
    RES_BYPASS = 2'd3
  } res_e;

endpackage

// File: rtl/tlbx_match.sv
// Per-entry tag compare; each entry compares under its own page size.
module tlbx_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int LVPN_W  = 10
) (
  input  logic [ENTRIES-1:0]            ent_valid,
  input  logic [ENTRIES-1:0]            ent_large,
  input  logic [ENTRIES-1:0][VPN_W-1:0] ent_tag,
  input  logic [VPN_W-1:0]              q_vpn,
  output logic [ENTRIES-1:0]            m_vec
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic small_eq;
    logic large_eq;
    assign small_eq = (ent_tag[g] == q_vpn);
    assign large_eq = (ent_tag[g][VPN_W-1 -: LVPN_W] == q_vpn[VPN_W-1 -: LVPN_W]);
    assign m_vec[g] = ent_valid[g] && (ent_large[g] ? large_eq : small_eq);
  end

endmodule

// File: rtl/tlbx_pick.sv
// Lowest-index priority encoder over a match vector.
module tlbx_pick #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] vec,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/tlbx_store.sv
// Entry storage with in-place refill, round-robin allocation and
// invalidate-by-address (invalidate wins over refill).
module tlbx_store #(
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 8,
  parameter int SMALL_SHIFT = 12,
  parameter int LARGE_SHIFT = 22
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       fill_en,
  input  logic [ADDR_W-1:0]                          fill_vaddr,
  input  logic [ADDR_W-1:0]                          fill_pte,
  input  logic                                       inv_en,
  input  logic [ADDR_W-1:0]                          inv_vaddr,
  output logic [ENTRIES-1:0]                         ent_valid,
  output logic [ENTRIES-1:0]                         ent_large,
  output logic [ENTRIES-1:0][ADDR_W-SMALL_SHIFT-1:0] ent_tag,
  output logic [ENTRIES-1:0][ADDR_W-1:0]             ent_pte
);
  import tlbx_pkg::*;

  localparam int VPN_W  = ADDR_W - SMALL_SHIFT;
  localparam int LVPN_W = ADDR_W - LARGE_SHIFT;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] pte_q;
  logic [IDX_W-1:0]              ptr_q;

  logic [ENTRIES-1:0] fill_vec;
  logic [ENTRIES-1:0] inv_vec;
  logic               fill_any;
  logic [IDX_W-1:0]   fill_idx;
  logic [IDX_W-1:0]   slot;
  logic [IDX_W-1:0]   ptr_nxt;
  logic               do_fill;
  logic               unused_lowbits;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_large
    assign ent_large[g] = pte_q[g][PTE_LARGE];
  end

  tlbx_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .LVPN_W(LVPN_W)) u_fill_match (
    .ent_valid (valid_q),
    .ent_large (ent_large),
    .ent_tag   (tag_q),
    .q_vpn     (fill_vaddr[ADDR_W-1:SMALL_SHIFT]),
    .m_vec     (fill_vec)
  );

  tlbx_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .LVPN_W(LVPN_W)) u_inv_match (
    .ent_valid (valid_q),
    .ent_large (ent_large),
    .ent_tag   (tag_q),
    .q_vpn     (inv_vaddr[ADDR_W-1:SMALL_SHIFT]),
    .m_vec     (inv_vec)
  );

  tlbx_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_fill_pick (
    .vec (fill_vec),
    .any (fill_any),
    .idx (fill_idx)
  );

  assign do_fill = fill_en && !inv_en;
  assign slot    = fill_any ? fill_idx : ptr_q;
  assign ptr_nxt = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;

  assign unused_lowbits = ^{fill_vaddr[SMALL_SHIFT-1:0], inv_vaddr[SMALL_SHIFT-1:0]};

  // Control state: valid flags and the replacement pointer.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (inv_en) begin
      valid_q <= valid_q & ~inv_vec;
    end else if (fill_en) begin
      valid_q[slot] <= 1'b1;
      if (!fill_any) ptr_q <= ptr_nxt;
    end
  end

  // Payload: write-enabled only, no reset.
  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[slot] <= fill_vaddr[ADDR_W-1:SMALL_SHIFT];
      pte_q[slot] <= fill_pte;
    end
  end

  assign ent_valid = valid_q;
  assign ent_tag   = tag_q;
  assign ent_pte   = pte_q;

endmodule

// File: rtl/tlbx_resolve.sv
// Permission check, dirty handling and physical address forming.
module tlbx_resolve #(
  parameter int ADDR_W      = 32,
  parameter int SMALL_SHIFT = 12,
  parameter int LARGE_SHIFT = 22
) (
  input  logic              paging_on,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              is_write,
  input  logic              is_user,
  input  logic              found,
  input  logic [ADDR_W-1:0] pte,
  output tlbx_pkg::res_e    res,
  output logic [ADDR_W-1:0] paddr,
  output logic              wthru,
  output logic              nocache
);
  import tlbx_pkg::*;

  logic denied;
  logic clean_write;
  logic unused_pte;

  assign denied = !pte[PTE_PRESENT]
               || (is_write && !pte[PTE_WRITE])
               || (is_user  && !pte[PTE_USER]);
  assign clean_write = is_write && !pte[PTE_DIRTY];
  assign unused_pte  = ^{pte[SMALL_SHIFT-1:PTE_LARGE+1], pte[PTE_ACCESSED]};

  always_comb begin
    res     = RES_MISS;
    paddr   = '0;
    wthru   = 1'b0;
    nocache = 1'b0;
    if (!paging_on) begin
      res   = RES_BYPASS;
      paddr = vaddr;
    end else if (!found) begin
      res = RES_MISS;
    end else if (denied) begin
      res = RES_FAULT;
    end else if (clean_write) begin
      res = RES_MISS;
    end else begin
      res     = RES_HIT;
      wthru   = pte[PTE_WTHRU];
      nocache = pte[PTE_NOCACHE];
      if (pte[PTE_LARGE])
        paddr = {pte[ADDR_W-1:LARGE_SHIFT], vaddr[LARGE_SHIFT-1:0]};
      else
        paddr = {pte[ADDR_W-1:SMALL_SHIFT], vaddr[SMALL_SHIFT-1:0]};
    end
  end

endmodule

// File: rtl/tlbx_xlate.sv
module tlbx_xlate #(
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 8,
  parameter int SMALL_SHIFT = 12,
  parameter int LARGE_SHIFT = 22,
  parameter int VEC_W       = 8,
  parameter int FAULT_VEC   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              paging_on,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_vaddr,
  input  logic              lk_write,
  input  logic              lk_user,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_vaddr,
  input  logic [ADDR_W-1:0] fill_pte,
  input  logic              inv_en,
  input  logic [ADDR_W-1:0] inv_vaddr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_paddr,
  output logic              out_hit,
  output logic              out_miss,
  output logic              out_fault,
  output logic [VEC_W-1:0]  out_fault_vec,
  output logic              out_wthru,
  output logic              out_nocache
);
  import tlbx_pkg::*;

  localparam int VPN_W  = ADDR_W - SMALL_SHIFT;
  localparam int LVPN_W = ADDR_W - LARGE_SHIFT;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0]             ent_large;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_tag;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_pte;

  logic [ENTRIES-1:0] lk_vec;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;

  res_e              res;
  logic [ADDR_W-1:0] res_paddr;
  logic              res_wthru;
  logic              res_nocache;

  tlbx_store #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES),
    .SMALL_SHIFT(SMALL_SHIFT), .LARGE_SHIFT(LARGE_SHIFT)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .fill_en    (fill_en),
    .fill_vaddr (fill_vaddr),
    .fill_pte   (fill_pte),
    .inv_en     (inv_en),
    .inv_vaddr  (inv_vaddr),
    .ent_valid  (ent_valid),
    .ent_large  (ent_large),
    .ent_tag    (ent_tag),
    .ent_pte    (ent_pte)
  );

  tlbx_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .LVPN_W(LVPN_W)) u_lk_match (
    .ent_valid (ent_valid),
    .ent_large (ent_large),
    .ent_tag   (ent_tag),
    .q_vpn     (lk_vaddr[ADDR_W-1:SMALL_SHIFT]),
    .m_vec     (lk_vec)
  );

  tlbx_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
    .vec (lk_vec),
    .any (lk_any),
    .idx (lk_idx)
  );

  tlbx_resolve #(
    .ADDR_W(ADDR_W), .SMALL_SHIFT(SMALL_SHIFT), .LARGE_SHIFT(LARGE_SHIFT)
  ) u_resolve (
    .paging_on (paging_on),
    .vaddr     (lk_vaddr),
    .is_write  (lk_write),
    .is_user   (lk_user),
    .found     (lk_any),
    .pte       (ent_pte[lk_idx]),
    .res       (res),
    .paddr     (res_paddr),
    .wthru     (res_wthru),
    .nocache   (res_nocache)
  );

  always_ff @(posedge clk) begin
    if (rst || !lk_valid) begin
      out_valid     <= 1'b0;
      out_paddr     <= '0;
      out_hit       <= 1'b0;
      out_miss      <= 1'b0;
      out_fault     <= 1'b0;
      out_fault_vec <= '0;
      out_wthru     <= 1'b0;
      out_nocache   <= 1'b0;
    end else begin
      out_valid     <= 1'b1;
      out_paddr     <= res_paddr;
      out_hit       <= (res == RES_HIT) || (res == RES_BYPASS);
      out_miss      <= (res == RES_MISS);
      out_fault     <= (res == RES_FAULT);
      out_fault_vec <= (res == RES_FAULT) ? VEC_W'(FAULT_VEC) : '0;
      out_wthru     <= res_wthru;
      out_nocache   <= res_nocache;
    end
  end

endmodule

// File: rtl/tlbx_xlate_chk.sv
module tlbx_xlate_chk #(
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              paging_on,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_vaddr,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_paddr,
  input logic              out_hit,
  input logic              out_miss,
  input logic              out_fault,
  input logic [VEC_W-1:0]  out_fault_vec,
  input logic              out_wthru,
  input logic              out_nocache
);

  // R1: the cycle after reset shows no result
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R2: bypass returns the address unchanged as a hit
  a_r2_bypass_identity: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(paging_on)) |->
      (out_hit && !out_fault && out_paddr == $past(lk_vaddr)));

  // R5: outcomes are mutually exclusive
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_hit, out_miss, out_fault}));

  // R6: fault vector accompanies fault and only fault
  a_r6_fault_vector: assert property (@(posedge clk) disable iff (rst)
    out_fault_vec == (out_fault ? VEC_W'(FAULT_VEC) : '0));

  // R10: one-cycle latency of the valid flag
  a_r10_valid_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(lk_valid)));

  // R10: idle outputs are all zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_paddr == '0 && !out_hit && !out_miss && !out_fault
                    && !out_wthru && !out_nocache));

endmodule

bind tlbx_xlate tlbx_xlate_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)
) u_chk (.*);

// File: tb/tb_tlbx_xlate.sv
module tb_tlbx_xlate;

  localparam int CLK_PERIOD = 10;
  localparam int NENT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        paging_on = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        lk_user = 1'b0;
  logic        fill_en = 1'b0;
  logic [31:0] fill_vaddr = '0;
  logic [31:0] fill_pte = '0;
  logic        inv_en = 1'b0;
  logic [31:0] inv_vaddr = '0;
  logic        out_valid;
  logic [31:0] out_paddr;
  logic        out_hit, out_miss, out_fault;
  logic [7:0]  out_fault_vec;
  logic        out_wthru, out_nocache;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbx_xlate dut (
    .clk(clk), .rst(rst), .paging_on(paging_on),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
    .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_pte(fill_pte),
    .inv_en(inv_en), .inv_vaddr(inv_vaddr),
    .out_valid(out_valid), .out_paddr(out_paddr), .out_hit(out_hit),
    .out_miss(out_miss), .out_fault(out_fault), .out_fault_vec(out_fault_vec),
    .out_wthru(out_wthru), .out_nocache(out_nocache)
  );

  // Reference model built from the requirements
  logic        m_valid [NENT];
  logic [19:0] m_tag   [NENT];
  logic [31:0] m_pte   [NENT];
  int          m_ptr;

  logic [46:0] exp_vec;
  string       exp_kind;

  function automatic logic m_match(int i, logic [31:0] va);
    if (!m_valid[i]) return 1'b0;
    if (m_pte[i][7]) return m_tag[i][19:10] == va[31:22];
    return m_tag[i] == va[31:12];
  endfunction

  function automatic int m_first(logic [31:0] va);
    for (int i = 0; i < NENT; i++) if (m_match(i, va)) return i;
    return -1;
  endfunction

  // packing: valid, paddr, hit, miss, fault, vec, wthru, nocache
  task automatic compute_expect();
    logic [31:0] pa;
    logic h, m, f, wt, nc;
    int k;
    logic [31:0] p;
    pa = '0; h = 0; m = 0; f = 0; wt = 0; nc = 0;
    if (!lk_valid) exp_kind = "R10";
    else if (!paging_on) begin pa = lk_vaddr; h = 1; exp_kind = "R2"; end
    else begin
      k = m_first(lk_vaddr);
      if (k < 0) begin m = 1; exp_kind = "R5"; end
      else begin
        p = m_pte[k];
        if (!p[0] || (lk_write && !p[1]) || (lk_user && !p[2])) begin
          f = 1; exp_kind = "R6";
        end else if (lk_write && !p[4]) begin
          m = 1; exp_kind = "R7";
        end else begin
          h = 1; wt = p[5]; nc = p[6];
          if (p[7]) begin pa = {p[31:22], lk_vaddr[21:0]}; exp_kind = "R4"; end
          else begin pa = {p[31:12], lk_vaddr[11:0]}; exp_kind = "R3"; end
        end
      end
    end
    exp_vec = {lk_valid, pa, h, m, f, (f ? 8'd5 : 8'd0), wt, nc};
  endtask

  task automatic model_update();
    int k;
    if (inv_en) begin
      for (int i = 0; i < NENT; i++) if (m_match(i, inv_vaddr)) m_valid[i] = 1'b0;
    end else if (fill_en) begin
      k = m_first(fill_vaddr);
      if (k < 0) begin k = m_ptr; m_ptr = (m_ptr + 1) % NENT; end
      m_valid[k] = 1'b1;
      m_tag[k]   = fill_vaddr[31:12];
      m_pte[k]   = fill_pte;
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NENT; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_pte[i] = '0;
    end
    m_ptr = 0;
  endtask

  function automatic logic [46:0] got_vec();
    return {out_valid, out_paddr, out_hit, out_miss, out_fault, out_fault_vec,
            out_wthru, out_nocache};
  endfunction

  // One clock: inputs already driven after a negedge.
  task automatic tick(string tag);
    logic [46:0] e;
    string k;
    compute_expect();
    e = exp_vec;
    k = (tag != "") ? tag : exp_kind;
    model_update();
    @(posedge clk);
    #2;
    n_chk++;
    if (got_vec() !== e) begin
      n_err++;
      $display("FAIL %s: got %h expected %h (valid,paddr,hit,miss,fault,vec,wt,nc)",
               k, got_vec(), e);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    lk_valid = 0; lk_write = 0; lk_user = 0; fill_en = 0; inv_en = 0;
  endtask

  task automatic fill(logic [31:0] va, logic [31:0] pte);
    idle(); fill_en = 1; fill_vaddr = va; fill_pte = pte;
    tick("R8");
    idle();
  endtask

  task automatic look(logic [31:0] va, logic w, logic u, string tag);
    idle(); lk_valid = 1; lk_vaddr = va; lk_write = w; lk_user = u;
    tick(tag);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst = 1; lk_valid = 1; lk_vaddr = 32'h1234_5678;
    @(posedge clk);
    #2;
    n_chk++;
    if (got_vec() !== '0) begin
      n_err++;
      $display("FAIL R1: outputs during reset %h expected 0", got_vec());
    end
    @(negedge clk);
    rst = 0; idle();
    model_clear();
  endtask

  logic [31:0] pool [12];

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    for (int k = 0; k < 12; k++)
      pool[k] = (k < 7) ? (32'h4010_0000 + k * 32'h1000) : (32'h4000_0000 + (k - 7) * 32'h0040_0000);
    repeat (2) @(negedge clk);
    paging_on = 1;
    do_reset();

    // R1: nothing cached after reset
    look(32'h0001_2345, 0, 0, "R1");

    // R3: 4 KB hit with write-through
    fill(32'h0001_2000, 32'hABCD_E03F);
    look(32'h0001_2345, 0, 0, "R3");
    look(32'h0001_2345, 1, 1, "R3");
    // R10: refill in lookup cycle not yet visible
    idle(); lk_valid = 1; lk_vaddr = 32'h0007_0010; fill_en = 1;
    fill_vaddr = 32'h0007_0000; fill_pte = 32'h0000_901F;
    tick("R10");
    look(32'h0007_0010, 0, 0, "R10");

    // R4: 4 MB page, far end of its range, cache-disable set
    fill(32'h8000_0000, 32'h1240_00DF);
    look(32'h803F_F123, 0, 0, "R4");

    // R6: three fault causes
    fill(32'h0002_0000, 32'h5555_501E);
    look(32'h0002_0004, 0, 0, "R6");
    fill(32'h0003_0000, 32'h6666_601D);
    look(32'h0003_0008, 1, 0, "R6");
    look(32'h0003_0008, 0, 0, "R6");
    idle();
    fill(32'h0004_0000, 32'h7777_701B);
    look(32'h0004_0010, 0, 1, "R6");

    // R7: clean write misses, then dirty refill hits in place (R8)
    fill(32'h0005_0000, 32'h8888_800F);
    look(32'h0005_0abc, 1, 0, "R7");
    look(32'h0005_0abc, 0, 0, "R7");
    fill(32'h0005_0000, 32'h8888_801F);
    look(32'h0005_0abc, 1, 0, "R8");

    // R2: paging disabled passes address through
    paging_on = 0;
    look(32'h0005_0abc, 1, 1, "R2");
    look(32'hFFFF_F001, 0, 0, "R2");
    paging_on = 1;

    // R9: invalidate by address, and priority over refill
    idle(); inv_en = 1; inv_vaddr = 32'h0001_2FFF;
    tick("R9");
    look(32'h0001_2000, 0, 0, "R9");
    idle(); inv_en = 1; inv_vaddr = 32'h0003_0000; fill_en = 1;
    fill_vaddr = 32'h0006_0000; fill_pte = 32'h9999_901F;
    tick("R9");
    idle();
    look(32'h0006_0000, 0, 0, "R9");
    look(32'h0003_0000, 0, 0, "R9");

    // R8: ninth distinct refill replaces the first
    do_reset();
    for (int k = 0; k < 9; k++) fill(32'h0100_0000 + k * 32'h1000, 32'h0A00_001F + k * 32'h1000);
    look(32'h0100_0000, 0, 0, "R8");
    look(32'h0100_1000, 0, 0, "R8");
    look(32'h0100_8000, 0, 0, "R8");

    // R11: 4 KB in slot 0 overlaps a 4 MB page in slot 1
    do_reset();
    fill(32'h4010_0000, 32'h0123_401F);
    fill(32'h4000_0000, 32'h0840_009F);
    look(32'h4010_0abc, 0, 0, "R11");
    look(32'h4020_0abc, 0, 0, "R11");
    idle(); inv_en = 1; inv_vaddr = 32'h4010_0000;
    tick("R9");
    look(32'h4020_0abc, 0, 0, "R9");

    // Random phase over overlapping pages
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      lk_valid  = ($urandom % 4) != 0;
      lk_vaddr  = pool[$urandom % 12] ^ ($urandom & 32'h0000_0FFF);
      lk_write  = $urandom % 2;
      lk_user   = $urandom % 2;
      paging_on = ($urandom % 16) != 0;
      fill_en   = ($urandom % 3) == 0;
      fill_vaddr = pool[$urandom % 12];
      fill_pte  = $urandom;
      fill_pte[0] = ($urandom % 8) != 0;
      inv_en    = ($urandom % 12) == 0;
      inv_vaddr = pool[$urandom % 12] ^ ($urandom & 32'h0000_0FFF);
      tick("");
    end
    idle();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule